// File: doc/BRIEF.md
# Dual Receive Buffer with Destination Filter

This block is the receive half of a small Ethernet MAC. Frame bytes arrive on a byte stream (valid, data, last). A state machine checks each frame's destination field against the station address and writes its bytes straight into whichever of two receive buffers is active. The frame is committed only when its last byte arrives and every rule is met. Commit sets the buffer's full flag, may raise a one-cycle interrupt pulse and, in alternating mode, hands the next frame to the other buffer.

Software works over a word-addressed register port. It reads frame bytes out of either buffer and reads or writes a control word per buffer. The control word holds the full flag and an interrupt enable. Writing the control word with the full flag clear returns that buffer to the receiver.

State machine: `ST_IDLE` waits for the first byte of a frame. On that byte it goes to `ST_DROP` if the active buffer is full, or to `ST_HDR` otherwise. A one-byte frame is decided in place. `ST_HDR` collects destination bytes 1 to 5 and leaves after byte 5 for `ST_BODY` (accepted) or `ST_DROP` (rejected). If the frame ends early it returns to `ST_IDLE`. `ST_BODY` stores payload and returns to `ST_IDLE` on the last byte with a commit. On reaching the size limit it goes to `ST_DROP`, or back to `ST_IDLE` without a commit when that byte is the last. `ST_DROP` ignores bytes until the last one and then returns to `ST_IDLE`.

Top module: `rxpp_top`

## Requirements
- R1: After reset both control words read zero, `irq` is low and the first committed frame lands in buffer 0.
- R2: A frame whose first byte has bit 7 set passes the destination filter whatever its other bytes and whatever its length, a one-byte frame included.
- R3: Any other frame passes only if it is at least 6 bytes long and bytes 0..5 equal `station_mac[47:40]` down to `station_mac[7:0]`. A failing frame changes no control word and raises no interrupt.
- R4: A frame whose first byte arrives while the active buffer's full flag is set is dropped, and the bytes held in that buffer stay unchanged.
- R5: A frame of 2020 bytes or more is dropped without any commit, while a frame of 2019 bytes is committed.
- R6: On commit the full flag (control bit 0) of the active buffer reads 1 from the cycle after the last byte. Frame byte i reads back in buffer word i/4, bits 8*(i%4)+7 down to 8*(i%4).
- R7: `irq` is high for exactly the one cycle after a commit's last byte, and only when the committing buffer's control bit 3 and `irq_global_en` were both 1 at that last byte.
- R8: With `pingpong_en` high the active buffer swaps after every commit. With it low every frame uses buffer 0.
- R9: Bit 10 of `bus_word` selects the buffer and word offset 0x1FF in bits 8..0 is its control word. That word reads bit 3 as the enable, bit 0 as the full flag and zero elsewhere, and a write stores `bus_wdata[3]` and `bus_wdata[0]`. Writing bit 0 as 0 frees the buffer.
- R10: When a commit and a control write to the same buffer fall in one cycle, the full flag ends at 1, the enable takes the written value and the interrupt follows the enable held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| station_mac | input | 48 | Station address, bits 47..40 compared with byte 0 |
| pingpong_en | input | 1 | Alternate between the two buffers |
| irq_global_en | input | 1 | Global interrupt enable |
| rx_valid | input | 1 | Stream byte valid |
| rx_data | input | 8 | Stream byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| bus_word | input | 11 | Register-port word address |
| bus_wr | input | 1 | Control-word write strobe |
| bus_wdata | input | 4 | Control write data, bits 3 and 0 used |
| bus_rdata | output | 32 | Combinational read data |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Two functions can fall in the same cycle: committing a frame and a software write to that buffer's control word. The bench provokes the overlap by raising the control write strobe on the exact cycle that carries a frame's last byte. It does this once with the old enable clear and a written enable of 1, and once the other way round. It judges the outcome by reading the control word afterwards and by counting interrupt pulses: the full flag must be set, the enable must match the written value, and a pulse must appear only in the case where the enable was set before the write.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_BODY,
        ST_DROP
    } rx_state_e;

    localparam int NBUF      = 2;
    localparam int HDR_BYTES = 6;
endpackage

// File: rtl/rxpp_da_filter.sv
module rxpp_da_filter (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [47:0] station_mac,
    input  logic        hdr_valid,
    input  logic [2:0]  byte_idx,
    input  logic [7:0]  in_byte,
    output logic        group_o,
    output logic        match_o
);
    logic       grp_q;
    logic       mism_q;
    logic [7:0] ref_b;
    logic       cur_eq;

    always_comb begin
        unique case (byte_idx)
            3'd0:    ref_b = station_mac[47:40];
            3'd1:    ref_b = station_mac[39:32];
            3'd2:    ref_b = station_mac[31:24];
            3'd3:    ref_b = station_mac[23:16];
            3'd4:    ref_b = station_mac[15:8];
            default: ref_b = station_mac[7:0];
        endcase
    end

    assign cur_eq  = (in_byte == ref_b);
    assign group_o = (byte_idx == 3'd0) ? in_byte[7] : grp_q;
    assign match_o = ((byte_idx == 3'd0) ? 1'b1 : !mism_q) & cur_eq;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q  <= 1'b0;
            mism_q <= 1'b0;
        end else if (hdr_valid) begin
            if (byte_idx == 3'd0) begin
                grp_q  <= in_byte[7];
                mism_q <= !cur_eq;
            end else begin
                mism_q <= mism_q | !cur_eq;
            end
        end
    end

    AST_GROUP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && byte_idx == 3'd0 |=> grp_q == $past(in_byte[7])); // R2
endmodule

// File: rtl/rxpp_buf.sv
module rxpp_buf #(
    parameter int DEPTH_W = 505,
    parameter int IDXW    = 11,
    parameter int WORD_W  = 9
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [IDXW-1:0]   wr_idx,
    input  logic [7:0]        wr_byte,
    input  logic              rd_sel,
    input  logic [WORD_W-1:0] rd_word,
    output logic [31:0]       rd_data
);
    localparam logic [WORD_W-1:0] DEPTH_LIM = WORD_W'(DEPTH_W);

    logic [31:0]       rd_g [rxpp_pkg::NBUF];
    logic [WORD_W-1:0] wr_word;
    logic [1:0]        wr_lane;

    assign wr_word = wr_idx[IDXW-1:2];
    assign wr_lane = wr_idx[1:0];

    for (genvar g = 0; g < rxpp_pkg::NBUF; g++) begin : g_bank
        logic [31:0] mem [DEPTH_W];

        always_ff @(posedge clk) begin
            if (wr_en && wr_sel == 1'(g) && wr_word < DEPTH_LIM) begin
                mem[wr_word][8*wr_lane +: 8] <= wr_byte;
            end
        end

        assign rd_g[g] = (rd_word < DEPTH_LIM) ? mem[rd_word] : 32'd0;
    end

    assign rd_data = rd_g[rd_sel];
endmodule

// File: rtl/rxpp_ctrl.sv
module rxpp_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl,
    input  logic       wr_sel,
    input  logic       wr_ie,
    input  logic       wr_full,
    input  logic       commit,
    input  logic       gie,
    input  logic       pingpong_en,
    output logic [1:0] full_o,
    output logic [1:0] ie_o,
    output logic       act_o,
    output logic       irq_o
);
    logic act_q;
    logic irq_q;

    assign act_o = pingpong_en & act_q;

    for (genvar g = 0; g < rxpp_pkg::NBUF; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                full_o[g] <= 1'b0;
                ie_o[g]   <= 1'b0;
            end else begin
                if (wr_ctrl && wr_sel == 1'(g)) begin
                    full_o[g] <= wr_full;
                    ie_o[g]   <= wr_ie;
                end
                if (commit && act_o == 1'(g)) begin
                    full_o[g] <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= commit & ie_o[act_o] & gie;
            if (commit) begin
                act_q <= pingpong_en ? ~act_q : 1'b0;
            end
        end
    end

    assign irq_o = irq_q;

    AST_COMMIT_FULL0: assert property (@(posedge clk) disable iff (!rst_n)
        commit && !act_o |=> full_o[0]); // R6
    AST_COMMIT_FULL1: assert property (@(posedge clk) disable iff (!rst_n)
        commit && act_o |=> full_o[1]); // R6
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(gie) && $past(commit)); // R7
    AST_FIXED_BUF0: assert property (@(posedge clk) disable iff (!rst_n)
        commit && !pingpong_en |=> !act_q); // R8
    AST_PP_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        commit && pingpong_en |=> act_q != $past(act_q)); // R8
endmodule

// File: rtl/rxpp_top.sv
module rxpp_top #(
    parameter int MAX_LEN = 2020
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [47:0] station_mac,
    input  logic        pingpong_en,
    input  logic        irq_global_en,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    input  logic [10:0] bus_word,
    input  logic        bus_wr,
    input  logic [3:0]  bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    import rxpp_pkg::*;

    localparam int IDXW    = $clog2(MAX_LEN);
    localparam int DEPTH_W = (MAX_LEN + 3) / 4;
    localparam int WORD_W  = 9;
    localparam logic [WORD_W-1:0] CTRL_WORD = '1;
    localparam logic [IDXW-1:0]   IDX_LIM   = IDXW'(MAX_LEN - 1);
    localparam logic [IDXW-1:0]   IDX_HLAST = IDXW'(HDR_BYTES - 1);

    rx_state_e       state_q, state_d;
    logic [IDXW-1:0] idx_q, idx_d;
    logic            commit, wr_en;
    logic            group, match, hdr_ok, hdr_valid;
    logic [1:0]      full, ie;
    logic            act, busy, wr_ctrl;
    logic [IDXW-1:0] wr_idx;
    logic [31:0]     buf_rd;

    assign busy      = full[act];
    assign hdr_ok    = group | match;
    assign hdr_valid = rx_valid && (state_q == ST_IDLE || state_q == ST_HDR);
    assign wr_idx    = (state_q == ST_IDLE) ? '0 : idx_q;
    assign wr_ctrl   = bus_wr && bus_word[WORD_W-1:0] == CTRL_WORD;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        commit  = 1'b0;
        wr_en   = 1'b0;
        unique case (state_q)
            ST_IDLE: if (rx_valid) begin
                if (busy) begin
                    state_d = rx_last ? ST_IDLE : ST_DROP;
                end else begin
                    wr_en = 1'b1;
                    idx_d = IDXW'(1);
                    if (rx_last) commit = group;
                    else         state_d = ST_HDR;
                end
            end
            ST_HDR: if (rx_valid) begin
                wr_en = 1'b1;
                idx_d = idx_q + 1'b1;
                if (idx_q == IDX_HLAST) begin
                    if (rx_last) begin
                        commit  = hdr_ok;
                        state_d = ST_IDLE;
                    end else begin
                        state_d = hdr_ok ? ST_BODY : ST_DROP;
                    end
                end else if (rx_last) begin
                    commit  = group;
                    state_d = ST_IDLE;
                end
            end
            ST_BODY: if (rx_valid) begin
                if (idx_q == IDX_LIM) begin
                    state_d = rx_last ? ST_IDLE : ST_DROP;
                end else begin
                    wr_en = 1'b1;
                    idx_d = idx_q + 1'b1;
                    if (rx_last) begin
                        commit  = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_DROP: if (rx_valid && rx_last) begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    rxpp_da_filter u_filter (
        .clk         (clk),
        .rst_n       (rst_n),
        .station_mac (station_mac),
        .hdr_valid   (hdr_valid),
        .byte_idx    (wr_idx[2:0]),
        .in_byte     (rx_data),
        .group_o     (group),
        .match_o     (match)
    );

    rxpp_buf #(.DEPTH_W(DEPTH_W), .IDXW(IDXW), .WORD_W(WORD_W)) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_sel  (act),
        .wr_idx  (wr_idx),
        .wr_byte (rx_data),
        .rd_sel  (bus_word[10]),
        .rd_word (bus_word[WORD_W-1:0]),
        .rd_data (buf_rd)
    );

    rxpp_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctrl     (wr_ctrl),
        .wr_sel      (bus_word[10]),
        .wr_ie       (bus_wdata[3]),
        .wr_full     (bus_wdata[0]),
        .commit      (commit),
        .gie         (irq_global_en),
        .pingpong_en (pingpong_en),
        .full_o      (full),
        .ie_o        (ie),
        .act_o       (act),
        .irq_o       (irq)
    );

    assign bus_rdata = (bus_word[WORD_W-1:0] == CTRL_WORD)
                     ? {28'd0, ie[bus_word[10]], 2'b00, full[bus_word[10]]}
                     : buf_rd;

    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DROP |-> !commit); // R4
    AST_HDR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HDR |-> idx_q <= IDX_HLAST && idx_q != '0); // R3
    AST_BODY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_BODY |-> idx_q <= IDX_LIM); // R5
    AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DROP |-> !wr_en); // R4
endmodule

// File: tb/tb_rxpp_top.sv
`timescale 1ns/1ps
module tb_rxpp_top;
    localparam logic [47:0] MAC = 48'h02_11_22_33_44_55;
    localparam int REFN = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pingpong_en = 1'b1;
    logic        irq_global_en = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'd0;
    logic        rx_last = 1'b0;
    logic [10:0] bus_word = 11'd0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_wdata = 4'd0;
    logic [31:0] bus_rdata;
    logic        irq;

    always #2 clk = ~clk;

    rxpp_top dut (
        .clk(clk), .rst_n(rst_n), .station_mac(MAC), .pingpong_en(pingpong_en),
        .irq_global_en(irq_global_en), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .bus_word(bus_word), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    int n_chk = 0, n_err = 0, irq_cnt = 0, exp_irq = 0;
    logic [7:0] fb [2048];
    logic [7:0] ref_b [2][REFN];
    int  ref_len [2];
    bit  exp_full [2];
    bit  exp_ie [2];
    bit  exp_raw = 1'b0;

    always @(negedge clk) if (rst_n && irq) irq_cnt++;

    task automatic chk(input string req, input string what,
                       input logic [31:0] actv, input logic [31:0] expv);
        n_chk++;
        if (actv !== expv) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, actv, expv);
        end
    endtask

    task automatic rd(input bit b, input int w, output logic [31:0] d);
        @(negedge clk);
        bus_word = {b, 10'(w)};
        #1 d = bus_rdata;
    endtask

    task automatic wr_ctrl(input bit b, input bit ie, input bit full);
        @(negedge clk);
        bus_word = {b, 10'h1FF}; bus_wdata = {ie, 2'b00, full}; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        exp_ie[b] = ie; exp_full[b] = full;
    endtask

    task automatic verify(input string req);
        logic [31:0] d;
        chk(req, "irq count", irq_cnt, exp_irq);
        for (int b = 0; b < 2; b++) begin
            rd(b[0], 9'h1FF, d);
            chk(req, $sformatf("ctrl%0d", b), d, {28'd0, exp_ie[b], 2'b00, exp_full[b]});
        end
    endtask

    task automatic check_buf(input bit b, input string req);
        logic [31:0] d;
        for (int i = 0; i < ref_len[b]; i++) begin
            rd(b, i / 4, d);
            chk(req, $sformatf("buf%0d byte%0d", b, i), {24'd0, d[8*(i%4) +: 8]}, {24'd0, ref_b[b][i]});
        end
    endtask

    function automatic bit addr_ok(input int len);
        bit uc = (len >= 6);
        for (int i = 0; i < 6; i++) if (fb[i] != MAC[8*(5-i) +: 8]) uc = 1'b0;
        return fb[0][7] || uc;
    endfunction

    task automatic mk(input int kind, input int len);
        for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
        for (int i = 0; i < 6; i++) fb[i] = MAC[8*(5-i) +: 8];
        if (kind == 0) fb[0] = fb[0] | 8'h80;
        else if (kind == 2) fb[3] = fb[3] ^ 8'h10;
    endtask

    task automatic send(input int len, input bit collide, input bit cie, input string req);
        bit b = pingpong_en & exp_raw;
        bit busy = exp_full[b];
        bit acc = !busy && addr_ok(len) && len < 2020;
        bit old_ie = exp_ie[b];
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = fb[i]; rx_last = (i == len - 1);
            if (collide && i == len - 1) begin
                bus_word = {b, 10'h1FF}; bus_wdata = {cie, 3'b000}; bus_wr = 1'b1;
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; bus_wr = 1'b0;
        if (collide) begin exp_ie[b] = cie; exp_full[b] = 1'b0; end
        if (acc) begin
            exp_full[b] = 1'b1;
            if (old_ie && irq_global_en) exp_irq++;
            ref_len[b] = (len < REFN) ? len : REFN;
            for (int i = 0; i < ref_len[b]; i++) ref_b[b][i] = fb[i];
            exp_raw = pingpong_en ? ~exp_raw : 1'b0;
        end
        repeat (2) @(negedge clk);
        verify(req);
        if (acc || busy) check_buf(b, req);
    endtask

    initial begin
        #(4ns * 200000);
        n_err++; n_chk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        verify("R1");
        chk("R1", "irq low", {31'd0, irq}, 32'd0);
        wr_ctrl(0, 1, 0); wr_ctrl(1, 1, 0);
        verify("R9");
        mk(2, 20); send(20, 0, 0, "R3");
        mk(1, 20); send(20, 0, 0, "R6");      // R1: first commit into buffer 0
        mk(0, 15); send(15, 0, 0, "R8");
        mk(0, 10); send(10, 0, 0, "R4");      // both full: dropped
        wr_ctrl(0, 1, 0); wr_ctrl(1, 1, 0);
        mk(1, 6); send(3, 0, 0, "R3");        // short unicast rejected
        mk(0, 6); send(1, 0, 0, "R2");        // one-byte group frame accepted
        wr_ctrl(0, 1, 0);
        irq_global_en = 1'b0;
        mk(0, 8); send(8, 0, 0, "R7");
        irq_global_en = 1'b1;
        wr_ctrl(1, 1, 0);
        mk(0, 2020); send(2020, 0, 0, "R5");
        mk(0, 2019); send(2019, 0, 0, "R5");
        wr_ctrl(0, 1, 0);
        pingpong_en = 1'b0;
        mk(1, 12); send(12, 0, 0, "R8");
        wr_ctrl(0, 1, 0);
        mk(0, 9); send(9, 0, 0, "R8");
        wr_ctrl(0, 0, 0);
        mk(1, 30); send(30, 1, 1, "R10");
        wr_ctrl(0, 1, 0);
        mk(0, 14); send(14, 1, 0, "R10");
        wr_ctrl(1, 0, 1);                     // software marks buffer 1 full
        rd(1, 9'h1FF, d);
        chk("R9", "sw full", d, 32'h1);
        wr_ctrl(0, 1, 0); wr_ctrl(1, 1, 0);
        for (int it = 0; it < 60; it++) begin
            int len = 1 + int'($urandom % 60);
            if (it % 20 == 0) pingpong_en = (it != 40);
            irq_global_en = ($urandom % 4) != 0;
            mk(int'($urandom % 3), len);
            send(len, 0, 0, "R8");
            if ($urandom % 2) wr_ctrl(1'($urandom), 1'($urandom), 1'b0);
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule